// File: doc/BRIEF.md
# Cascadable Eight-Level Interrupt Controller

The block collects eight interrupt request lines and decides which one the processor should service next. A byte-wide register port with one address line (`a0`) carries all commands. An initialization sequence sets the vector base and the cascade layout. After that, the port accepts mask writes, end-of-interrupt commands, read-select commands and poll commands. Priority is fixed: input 0 is highest and input 7 is lowest. A request is offered on `int_out` only while it outranks every level already in service.

Acknowledge happens through a poll. Software writes a poll command, and the next control read returns the winning level and moves that level into service. Two instances can be cascaded. The slave's `int_out` feeds one master input, and that input is named as a cascade input during initialization. When the master reports that input, software polls the slave for the final level. The slave's vector base of 0x08 places its levels at 8 to 15 on the `vector` output.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, the mask register reads 0xFF, `int_out` is low, and a control read (`a0`=0) returns the request register, which is 0x00.
- R2: A control write with bit 4 set starts initialization. The bit 1 value 0 means cascaded and the bit 0 value 1 means a mode word follows. The following data writes (`a0`=1) are taken in order as vector base, cascade word (skipped when bit 1 was set) and mode word (skipped when bit 0 was clear). Only the next data write after that reaches the mask.
- R3: After initialization, a data write loads the mask and a data read returns it. A set mask bit n keeps input n off `int_out`, but its latched request is kept.
- R4: A rising edge on input n sets request bit n. The bit clears when the input falls or when the level is acknowledged. An input that stays high after acknowledge raises no new request.
- R5: `int_out` is high exactly when the lowest-numbered unmasked request is lower in number than every in-service bit.
- R6: Control write 0x0C arms a poll. The next control read returns bit 7 = 1 and bits 2:0 = the winning level. That read sets the level's in-service bit and clears its request bit. Later reads return the selected register again.
- R7: Control write 0x0B selects the in-service register and 0x0A selects the request register for non-poll control reads. The selection persists across polls and end-of-interrupt commands.
- R8: Control write 0x20 clears the lowest-numbered set in-service bit only.
- R9: A poll read while no request qualifies returns 0x07 and changes no in-service bit. This also holds when input 7 was raised and dropped before the poll.
- R10: `vector` equals bits 7:3 of the vector base word concatenated with the 3-bit winning level.
- R11: With `is_master` high, `cas_sel` is high while `int_out` is high and the winning input has its bit set in the cascade word. A slave's `int_out` driving such an input makes the master report that input's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | High selects the master role for cascade decoding |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| a0 | input | 1 | Register select: 0 control, 1 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| irq_in | input | 8 | Interrupt request inputs, synchronous to `clk` |
| int_out | output | 1 | Interrupt pending toward the processor or master |
| vector | output | 8 | Vector base with the winning level |
| cas_sel | output | 1 | Master: winning input is a cascade input |

## Verification
Every single level from 0 to 7 is raised on its own, first masked and then unmasked. This separates the mask gating, the level encoding, the vector output and the cascade flag for each input. All 28 ordered pairs of simultaneous requests are run through poll and end-of-interrupt. They show lowest-number-first selection, and they show that an in-service level blocks a lower-priority request until its end-of-interrupt arrives. A nested case with a later higher-priority arrival checks that the end-of-interrupt clears only the top in-service bit. A sweep over all slave inputs through the master, a short input-7 pulse, and a single-controller re-initialization then separate the cascade path, the spurious-level result and the skipping of init words.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        INIT_DONE = 2'd0,
        INIT_VEC  = 2'd1,
        INIT_CAS  = 2'd2,
        INIT_MODE = 2'd3
    } init_st_e;

    localparam int          CMD_INIT_BIT = 4;
    localparam int          CMD_OCW3_BIT = 3;
    localparam int          CMD_POLL_BIT = 2;
    localparam int          CMD_RSEL_BIT = 1;
    localparam int          CMD_RISR_BIT = 0;
    localparam int          INIT_SNGL_BIT = 1;
    localparam int          INIT_IC4_BIT  = 0;
    localparam logic [2:0]  EOI_NONSPEC  = 3'b001;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N  = 8,
    parameter int LW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [LW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k]) idx = LW'(k);
        end
    end
endmodule

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
    parameter int N = 8
) (
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] irr,
    input  logic [N-1:0] take,
    input  logic         flush,
    output logic [N-1:0] irr_nx
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign irr_nx[g] = ~flush & ~take[g] & lvl[g] & (irr[g] | ~prev[g]);
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_master,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [N_IN-1:0] irq_in,
    output logic          int_out,
    output logic [DW-1:0] vector,
    output logic          cas_sel
);
    localparam int LW = $clog2(N_IN);
    localparam int VB = DW - LW;

    typedef struct packed {
        init_st_e        st;
        logic            sngl;
        logic            ic4;
        logic [VB-1:0]   vbase;
        logic [N_IN-1:0] cas;
        logic [N_IN-1:0] mask;
        logic [N_IN-1:0] irr;
        logic [N_IN-1:0] isr;
        logic [N_IN-1:0] prev;
        logic            rd_isr;
        logic            poll_arm;
    } regs_t;

    regs_t st_d, st_q;

    logic [N_IN-1:0] req_vec, ack_vec, irr_nx;
    logic            r_any, i_any, pend;
    logic [LW-1:0]   r_idx, i_idx;
    logic            wr_ctl, icw1_hit, poll_rd, poll_take;
    logic [DW-1:0]   poll_byte;

    // observation points for the bound checker
    logic [N_IN-1:0] obs_mask, obs_irr, obs_isr;
    logic            obs_poll, obs_done;

    assign req_vec = st_q.irr & ~st_q.mask;

    pic_prio_enc #(.N(N_IN), .LW(LW)) u_req_enc (
        .vec (req_vec),
        .any (r_any),
        .idx (r_idx)
    );

    pic_prio_enc #(.N(N_IN), .LW(LW)) u_isr_enc (
        .vec (st_q.isr),
        .any (i_any),
        .idx (i_idx)
    );

    assign pend      = r_any & (~i_any | (r_idx < i_idx));
    assign wr_ctl    = wr_en & ~a0;
    assign icw1_hit  = wr_ctl & wdata[CMD_INIT_BIT];
    assign poll_rd   = rd_en & ~a0 & st_q.poll_arm;
    assign poll_take = poll_rd & pend;
    assign ack_vec   = poll_take ? (N_IN'(1) << r_idx) : '0;

    pic_edge_latch #(.N(N_IN)) u_edge (
        .lvl    (irq_in),
        .prev   (st_q.prev),
        .irr    (st_q.irr),
        .take   (ack_vec),
        .flush  (icw1_hit),
        .irr_nx (irr_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        st_d.irr  = irr_nx;

        if (poll_rd) begin
            st_d.poll_arm = 1'b0;
            if (pend) st_d.isr[r_idx] = 1'b1;
        end

        if (icw1_hit) begin
            st_d.st       = INIT_VEC;
            st_d.sngl     = wdata[INIT_SNGL_BIT];
            st_d.ic4      = wdata[INIT_IC4_BIT];
            st_d.isr      = '0;
            st_d.rd_isr   = 1'b0;
            st_d.poll_arm = 1'b0;
        end else if (wr_ctl) begin
            if (wdata[CMD_OCW3_BIT]) begin
                if (wdata[CMD_POLL_BIT]) st_d.poll_arm = 1'b1;
                if (wdata[CMD_RSEL_BIT]) st_d.rd_isr = wdata[CMD_RISR_BIT];
            end else if (wdata[DW-1:DW-3] == EOI_NONSPEC && i_any) begin
                st_d.isr[i_idx] = 1'b0;
            end
        end else if (wr_en && a0) begin
            unique case (st_q.st)
                INIT_VEC: begin
                    st_d.vbase = wdata[DW-1:LW];
                    if (!st_q.sngl)     st_d.st = INIT_CAS;
                    else if (st_q.ic4)  st_d.st = INIT_MODE;
                    else                st_d.st = INIT_DONE;
                end
                INIT_CAS: begin
                    st_d.cas = wdata[N_IN-1:0];
                    st_d.st  = st_q.ic4 ? INIT_MODE : INIT_DONE;
                end
                INIT_MODE: st_d.st = INIT_DONE;
                default:   st_d.mask = wdata[N_IN-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.st       <= INIT_DONE;
            st_q.mask     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        poll_byte           = '0;
        poll_byte[DW-1]     = pend;
        poll_byte[LW-1:0]   = pend ? r_idx : LW'(N_IN - 1);
        if (a0)                 rdata = DW'(st_q.mask);
        else if (st_q.poll_arm) rdata = poll_byte;
        else if (st_q.rd_isr)   rdata = DW'(st_q.isr);
        else                    rdata = DW'(st_q.irr);
    end

    assign int_out  = pend;
    assign vector   = {st_q.vbase, r_idx};
    assign cas_sel  = is_master & pend & st_q.cas[r_idx];

    assign obs_mask = st_q.mask;
    assign obs_irr  = st_q.irr;
    assign obs_isr  = st_q.isr;
    assign obs_poll = st_q.poll_arm;
    assign obs_done = (st_q.st == INIT_DONE);
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         is_master,
    input logic         wr_en,
    input logic         rd_en,
    input logic         a0,
    input logic [N-1:0] wdata,
    input logic [N-1:0] irq_in,
    input logic         int_out,
    input logic         cas_sel,
    input logic [N-1:0] mask_w,
    input logic [N-1:0] irr_w,
    input logic [N-1:0] isr_w,
    input logic         poll_w,
    input logic         done_w
);
    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a0 && done_w) |=> (mask_w == $past(wdata)));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irr_w & ~$past(irq_in)) == '0));

    // R5
    int_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_w & ~mask_w) != '0));

    // R6
    poll_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !a0 && poll_w && int_out && !wr_en)
        |=> ($countones(isr_w) == $countones($past(isr_w)) + 1) && !poll_w);

    // R8
    eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !a0 && wdata == N'(8'h20) && isr_w != '0 && !rd_en)
        |=> ($countones(isr_w) + 1 == $countones($past(isr_w))));

    // R9
    spur_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !a0 && poll_w && !int_out && !wr_en) |=> $stable(isr_w));

    // R11
    cas_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_sel |-> (int_out && is_master));
endmodule

bind pic8_ctrl pic8_ctrl_chk #(.N(N_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_master (is_master),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .a0        (a0),
    .wdata     (wdata[N_IN-1:0]),
    .irq_in    (irq_in),
    .int_out   (int_out),
    .cas_sel   (cas_sel),
    .mask_w    (obs_mask),
    .irr_w     (obs_irr),
    .isr_w     (obs_isr),
    .poll_w    (obs_poll),
    .done_w    (obs_done)
);

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a0 = 1'b0;
    logic [7:0] wdata = '0;
    logic       m_wr = 1'b0, m_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
    logic [7:0] m_rdata, s_rdata, m_vec, s_vec;
    logic [7:0] m_irq = '0, s_irq = '0;
    logic       m_int, s_int, m_cas, s_cas;
    logic [7:0] m_in;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;

    assign m_in = m_irq | {5'b0, s_int, 2'b0};

    pic8_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1),
        .wr_en(m_wr), .rd_en(m_rd), .a0(a0), .wdata(wdata), .rdata(m_rdata),
        .irq_in(m_in), .int_out(m_int), .vector(m_vec), .cas_sel(m_cas)
    );

    pic8_ctrl u_slv (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0),
        .wr_en(s_wr), .rd_en(s_rd), .a0(a0), .wdata(wdata), .rdata(s_rdata),
        .irq_in(s_irq), .int_out(s_int), .vector(s_vec), .cas_sel(s_cas)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit slv, input bit a, input logic [7:0] d);
        @(negedge clk);
        a0 = a; wdata = d;
        if (slv) s_wr = 1'b1; else m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic rd(input bit slv, input bit a, output logic [7:0] d);
        @(negedge clk);
        a0 = a;
        if (slv) s_rd = 1'b1; else m_rd = 1'b1;
        #5 d = slv ? s_rdata : m_rdata;
        @(negedge clk);
        m_rd = 1'b0; s_rd = 1'b0;
    endtask

    task automatic poll(input bit slv, output logic [7:0] d);
        wr(slv, 1'b0, 8'h0C);
        rd(slv, 1'b0, d);
    endtask

    initial begin
        #(20 * 200000);
        failures++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 1, d); check("R1 mask", d, 8'hFF);
        check("R1 int", {7'b0, m_int}, 8'h00);
        rd(0, 0, d); check("R1 irr", d, 8'h00);

        // R2 cascaded init on both
        wr(0, 0, 8'h11); wr(0, 1, 8'h00); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        wr(1, 0, 8'h11); wr(1, 1, 8'h08); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
        rd(0, 1, d); check("R2 init words not in mask", d, 8'hFF);
        wr(0, 1, 8'h00); rd(0, 1, d); check("R3 mask readback", d, 8'h00);
        wr(1, 1, 8'h00);
        wr(0, 0, 8'h0B); wr(1, 0, 8'h0B);

        // single level sweep
        for (int i = 0; i < 8; i++) begin
            wr(0, 1, 8'(1 << i));
            m_irq[i] = 1'b1;
            @(negedge clk);
            check("R3 masked no int", {7'b0, m_int}, 8'h00);
            wr(0, 1, 8'h00);
            check("R3 unmask keeps request", {7'b0, m_int}, 8'h01);
            check("R10 vector", m_vec, 8'(i));
            check("R11 cas flag", {7'b0, m_cas}, {7'b0, i == 2});
            poll(0, d); check("R6 poll result", d, 8'h80 | 8'(i));
            rd(0, 0, d); check("R7 isr after poll", d, 8'(1 << i));
            check("R4 held high no new int", {7'b0, m_int}, 8'h00);
            wr(0, 0, 8'h0A); rd(0, 0, d); check("R4 irr cleared by ack", d, 8'h00);
            wr(0, 0, 8'h0B);
            wr(0, 0, 8'h20); rd(0, 0, d); check("R8 eoi clears", d, 8'h00);
            m_irq = '0;
            @(negedge clk);
        end

        // pair sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                m_irq[i] = 1'b1; m_irq[j] = 1'b1;
                @(negedge clk);
                check("R5 int pair", {7'b0, m_int}, 8'h01);
                check("R5 winner", m_vec, 8'(i));
                poll(0, d); check("R6 poll pair", d, 8'h80 | 8'(i));
                check("R5 blocked by isr", {7'b0, m_int}, 8'h00);
                wr(0, 0, 8'h20);
                check("R5 lower after eoi", m_vec, 8'(j));
                check("R5 int after eoi", {7'b0, m_int}, 8'h01);
                poll(0, d); check("R6 poll second", d, 8'h80 | 8'(j));
                wr(0, 0, 8'h20);
                rd(0, 0, d); check("R7 isr persists empty", d, 8'h00);
                m_irq = '0;
                @(negedge clk);
            end
        end

        // nested: higher arrives while lower in service
        m_irq[5] = 1'b1; @(negedge clk);
        poll(0, d); check("R6 nested first", d, 8'h85);
        m_irq[1] = 1'b1; @(negedge clk);
        check("R5 higher preempts", {7'b0, m_int}, 8'h01);
        poll(0, d); check("R6 nested second", d, 8'h81);
        rd(0, 0, d); check("R7 isr two bits", d, 8'h22);
        wr(0, 0, 8'h20); rd(0, 0, d); check("R8 top bit only", d, 8'h20);
        wr(0, 0, 8'h20); rd(0, 0, d); check("R8 last bit", d, 8'h00);
        m_irq = '0; @(negedge clk);

        // spurious level 7
        m_irq[7] = 1'b1; @(negedge clk);
        check("R9 int on 7", {7'b0, m_int}, 8'h01);
        m_irq[7] = 1'b0; @(negedge clk);
        check("R4 drop clears", {7'b0, m_int}, 8'h00);
        poll(0, d); check("R9 spurious poll", d, 8'h07);
        rd(0, 0, d); check("R9 isr untouched", d, 8'h00);
        poll(0, d); check("R9 idle poll", d, 8'h07);

        // cascade sweep
        for (int k = 0; k < 8; k++) begin
            s_irq[k] = 1'b1;
            @(negedge clk); @(negedge clk);
            check("R11 master int", {7'b0, m_int}, 8'h01);
            check("R11 master cas", {7'b0, m_cas}, 8'h01);
            check("R11 slave cas low", {7'b0, s_cas}, 8'h00);
            check("R10 slave vector", s_vec, 8'h08 | 8'(k));
            poll(0, d); check("R11 master poll", d, 8'h82);
            poll(1, d); check("R6 slave poll", d, 8'h80 | 8'(k));
            rd(1, 0, d); check("R7 slave isr", d, 8'(1 << k));
            wr(1, 0, 8'h20); wr(0, 0, 8'h20);
            s_irq = '0; @(negedge clk);
            check("R11 master idle", {7'b0, m_int}, 8'h00);
        end

        // R2 single controller, no mode word
        wr(0, 0, 8'h12); wr(0, 1, 8'h28); wr(0, 1, 8'h5A);
        rd(0, 1, d); check("R2 skip to mask", d, 8'h5A);
        m_irq[0] = 1'b1; @(negedge clk);
        check("R10 new base", m_vec, 8'h28);
        rd(0, 0, d); check("R7 init selects irr", d, 8'h01);
        m_irq = '0; @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule